// File: doc/BRIEF.md
# Link-Side Packet Bus Transmitter

This block sits on the link-layer side of a multi-port packet bus and sends packets toward the physical-layer device. Packets arrive one byte per beat on a valid/ready stream. Each byte carries an end-of-packet marker, an error marker that counts only on the final byte, and a 5-bit destination port that is captured from the first byte of the packet. The block packs the bytes into 16-bit bus words, first byte on the upper half. It generates start, end, modulo, error and parity, and drives the words onto the transmit bus under an active-low write enable.

Before each packet the block presents the destination port on the address lines for at least one cycle with the enable high. This is the selection phase. It then transfers words with the enable low. The physical layer reports back on a per-port "room available" flag for the selected port. When that flag is sampled low, the block withholds the enable and keeps the same word pending until the flag returns. The next word is then sent, with nothing lost or repeated.

Back-pressure on the input follows the usual stream rules. A byte moves only in a cycle where `s_valid` and `s_ready` are both high. While `s_valid` is high and `s_ready` is low, the source holds the byte and its markers steady. `s_ready` falls whenever the one-word output slot is occupied and not being taken, or while the second word of a short packet is still queued.

Top module: `pktx_link_tx`

## Requirements
- R1: Out of reset, `tx_enb_n` is 1, `tx_addr` is 5'h1F, `tx_sop`, `tx_eop`, `tx_mod`, `tx_err` and `tx_data` are 0, and `s_ready` is 1.
- R2: The first word of every packet is immediately preceded by a cycle with `tx_enb_n` = 1 and `tx_addr` equal to that packet's port. `tx_addr` keeps that port on every word of the packet.
- R3: The first word of each packet has `tx_sop` = 1 and `tx_enb_n` = 0. While `tx_enb_n` = 1, `tx_sop`, `tx_eop`, `tx_mod`, `tx_err` and `tx_data` are all 0.
- R4: For packets of three or more bytes, byte 2k of the packet appears on `tx_data[15:8]` and byte 2k+1 on `tx_data[7:0]` of word k.
- R5: The final word carries `tx_mod` = 1 when it holds a single byte. That byte is on `tx_data[15:8]` and `tx_data[7:0]` is 0. A final word holding two bytes has `tx_mod` = 0.
- R6: `tx_mod` and `tx_err` are 0 on every word without `tx_eop`. `tx_err` on the end word equals `s_err` of the packet's last byte. `s_err` on other bytes has no effect.
- R7: `tx_sop` and `tx_eop` are never 1 together. Packets of one or two bytes are sent as two words. The start word is {byte0, 8'h00} with `tx_mod` = 0. The end word has `tx_mod` = 1 and carries {byte1, 8'h00} for two bytes or 16'h0000 for one byte.
- R8: In every cycle `tx_par` equals the XOR of all 16 `tx_data` bits XOR `par_odd`. `par_odd` = 0 gives even parity and `par_odd` = 1 gives odd parity.
- R9: The null address 5'h1F is never on `tx_addr` while `tx_enb_n` = 0. When no packet is pending after an end word, `tx_addr` returns to 5'h1F with `tx_enb_n` = 1.
- R10: A word is driven with `tx_enb_n` = 0 only if `tx_avail` was 1 in the previous cycle. A packet that stalls on a low `tx_avail` resumes where it stopped, with no word lost or repeated.
- R11: Back-to-back packets to different ports each receive their own selection cycle and their own port address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Input byte accepted when high with s_valid |
| s_data | input | 8 | Packet byte |
| s_last | input | 1 | Marks the packet's last byte |
| s_err | input | 1 | Packet error, taken on the last byte only |
| s_port | input | 5 | Destination port, captured on the first byte |
| par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| tx_avail | input | 1 | Selected port has room |
| tx_enb_n | output | 1 | Active-low write enable |
| tx_addr | output | 5 | Port address, 5'h1F when idle |
| tx_data | output | 16 | Bus word, big-endian |
| tx_sop | output | 1 | Start-of-packet word |
| tx_eop | output | 1 | End-of-packet word |
| tx_mod | output | 1 | Final word holds a single byte |
| tx_err | output | 1 | Packet error on the end word |
| tx_par | output | 1 | Parity over tx_data |

## Verification
Every bus output is a register. A word appears one cycle after the edge at which `tx_avail` was high with a word pending. The selection cycle appears one edge after a packer word is first visible. Parity is combinational on the registered data and `par_odd`, in the same cycle. The bench does not count the input-to-bus latency. A monitor samples at the falling edge, records every enabled word together with the previous cycle's enable, address and `tx_avail`, and compares the recorded words with lists computed from the packet length and byte values. Inputs change one time step after the rising edge, so the falling-edge sample of `tx_avail` is exactly the value the design saw at the next edge.

// File: rtl/pktx_pkg.sv
package pktx_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 2;
  localparam int WORD_W = BYTE_W * LANES;
  localparam int PORT_W = 5;
  localparam logic [PORT_W-1:0] NULL_PORT = '1;

  typedef struct packed {
    logic [WORD_W-1:0] data;
    logic              sop;
    logic              eop;
    logic              mod;
    logic              err;
    logic [PORT_W-1:0] port;
  } word_t;

  typedef enum logic {ST_IDLE, ST_PKT} bus_st_t;
endpackage

// File: rtl/pktx_parity.sv
module pktx_parity #(
  parameter int W = 16
) (
  input  logic [W-1:0] d,
  input  logic         odd,
  output logic         p
);
  logic [W-1:0] chain;

  // ripple XOR: chain[i] holds the parity of bits 0..i
  assign chain[0] = d[0];
  for (genvar i = 1; i < W; i++) begin : g_chain
    assign chain[i] = chain[i-1] ^ d[i];
  end

  assign p = chain[W-1] ^ odd;
endmodule

// File: rtl/pktx_packer.sv
module pktx_packer
  import pktx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  input  logic              in_err,
  input  logic [PORT_W-1:0] in_port,
  output logic              o_valid,
  input  logic              o_ready,
  output word_t             o_word
);
  localparam logic [BYTE_W-1:0] ZB = '0;

  logic              o_full, o_pop, acc;
  logic              t_pend;
  word_t             t_word;
  logic              have_hi, first_w;
  logic [BYTE_W-1:0] hi_byte;
  logic [PORT_W-1:0] cur_port, port_sel;
  logic              emit, e_tail;
  word_t             e_word, e_tail_word;

  assign o_pop    = o_full && o_ready;
  assign in_ready = (!o_full || o_pop) && !t_pend;
  assign acc      = in_valid && in_ready;
  assign o_valid  = o_full;
  assign port_sel = (first_w && !have_hi) ? in_port : cur_port;

  always_comb begin
    emit        = 1'b0;
    e_tail      = 1'b0;
    e_word      = '0;
    e_tail_word = '0;
    e_word.port      = port_sel;
    e_tail_word.port = port_sel;
    if (acc) begin
      if (!have_hi) begin
        if (in_last) begin
          emit        = 1'b1;
          e_word.data = {in_data, ZB};
          if (first_w) begin
            // single-byte packet: start word, then padded end word
            e_word.sop      = 1'b1;
            e_tail          = 1'b1;
            e_tail_word.eop = 1'b1;
            e_tail_word.mod = 1'b1;
            e_tail_word.err = in_err;
          end else begin
            e_word.eop = 1'b1;
            e_word.mod = 1'b1;
            e_word.err = in_err;
          end
        end
      end else begin
        emit = 1'b1;
        if (in_last && first_w) begin
          // two-byte packet split so start and end stay apart
          e_word.data      = {hi_byte, ZB};
          e_word.sop       = 1'b1;
          e_tail           = 1'b1;
          e_tail_word.data = {in_data, ZB};
          e_tail_word.eop  = 1'b1;
          e_tail_word.mod  = 1'b1;
          e_tail_word.err  = in_err;
        end else begin
          e_word.data = {hi_byte, in_data};
          e_word.sop  = first_w;
          e_word.eop  = in_last;
          e_word.err  = in_last && in_err;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_full   <= 1'b0;
      o_word   <= '0;
      t_pend   <= 1'b0;
      t_word   <= '0;
      have_hi  <= 1'b0;
      hi_byte  <= '0;
      first_w  <= 1'b1;
      cur_port <= NULL_PORT;
    end else begin
      if (acc) begin
        if (first_w && !have_hi) cur_port <= in_port;
        if (!have_hi && !in_last) begin
          have_hi <= 1'b1;
          hi_byte <= in_data;
        end else begin
          have_hi <= 1'b0;
        end
      end
      if (emit) begin
        first_w <= in_last;
        o_word  <= e_word;
        o_full  <= 1'b1;
        if (e_tail) begin
          t_pend <= 1'b1;
          t_word <= e_tail_word;
        end
      end else if (t_pend && (!o_full || o_pop)) begin
        o_word <= t_word;
        o_full <= 1'b1;
        t_pend <= 1'b0;
      end else if (o_pop) begin
        o_full <= 1'b0;
      end
    end
  end

  // a queued tail word must never be overwritten by a new byte
  p_tail_blocks_input_r7: assert property (@(posedge clk) disable iff (!rst_n)
    t_pend |-> !in_ready);
  // a tail is only queued behind its own start word
  p_tail_follows_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(t_pend) |-> (o_full && o_word.sop && !o_word.eop));
endmodule

// File: rtl/pktx_bus_ctrl.sv
module pktx_bus_ctrl
  import pktx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              w_valid,
  output logic              w_ready,
  input  word_t             w_word,
  input  logic              avail,
  output logic              enb_n,
  output logic [PORT_W-1:0] addr,
  output logic [WORD_W-1:0] data,
  output logic              sop,
  output logic              eop,
  output logic              mod,
  output logic              err
);
  bus_st_t st;
  logic    pop;

  assign w_ready = (st == ST_PKT) && avail;
  assign pop     = w_valid && w_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      enb_n <= 1'b1;
      addr  <= NULL_PORT;
      data  <= '0;
      sop   <= 1'b0;
      eop   <= 1'b0;
      mod   <= 1'b0;
      err   <= 1'b0;
    end else begin
      data <= '0;
      sop  <= 1'b0;
      eop  <= 1'b0;
      mod  <= 1'b0;
      err  <= 1'b0;
      enb_n <= 1'b1;
      case (st)
        ST_IDLE: begin
          if (w_valid) begin
            addr <= w_word.port;   // selection cycle
            st   <= ST_PKT;
          end else begin
            addr <= NULL_PORT;
          end
        end
        default: begin
          if (pop) begin
            enb_n <= 1'b0;
            data  <= w_word.data;
            sop   <= w_word.sop;
            eop   <= w_word.eop;
            mod   <= w_word.mod;
            err   <= w_word.err;
            if (w_word.eop) st <= ST_IDLE;
          end
        end
      endcase
    end
  end

  p_select_before_sop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!enb_n && sop) |-> ($past(enb_n) && ($past(addr) == addr)));
  p_quiet_when_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    enb_n |-> !(sop || eop || mod || err));
  p_mod_lower_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mod |-> (data[BYTE_W-1:0] == '0));
  p_mod_err_only_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mod || err) |-> eop);
  p_sop_eop_apart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(sop && eop));
  p_no_null_on_xfer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enb_n |-> (addr != NULL_PORT));
  p_word_needs_avail_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enb_n |-> $past(avail));
endmodule

// File: rtl/pktx_link_tx.sv
module pktx_link_tx
  import pktx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_last,
  input  logic              s_err,
  input  logic [PORT_W-1:0] s_port,
  input  logic              par_odd,
  input  logic              tx_avail,
  output logic              tx_enb_n,
  output logic [PORT_W-1:0] tx_addr,
  output logic [WORD_W-1:0] tx_data,
  output logic              tx_sop,
  output logic              tx_eop,
  output logic              tx_mod,
  output logic              tx_err,
  output logic              tx_par
);
  logic  w_valid, w_ready;
  word_t w_word;

  pktx_packer u_packer (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (s_valid),
    .in_ready (s_ready),
    .in_data  (s_data),
    .in_last  (s_last),
    .in_err   (s_err),
    .in_port  (s_port),
    .o_valid  (w_valid),
    .o_ready  (w_ready),
    .o_word   (w_word)
  );

  pktx_bus_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .w_valid (w_valid),
    .w_ready (w_ready),
    .w_word  (w_word),
    .avail   (tx_avail),
    .enb_n   (tx_enb_n),
    .addr    (tx_addr),
    .data    (tx_data),
    .sop     (tx_sop),
    .eop     (tx_eop),
    .mod     (tx_mod),
    .err     (tx_err)
  );

  pktx_parity #(.W(WORD_W)) u_par (
    .d   (tx_data),
    .odd (par_odd),
    .p   (tx_par)
  );
endmodule

// File: tb/pktx_link_tx_tb_top.sv
module pktx_link_tx_tb_top;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [7:0]  s_data = '0;
  logic        s_last = 1'b0;
  logic        s_err = 1'b0;
  logic [4:0]  s_port = '0;
  logic        par_odd = 1'b0;
  logic        tx_avail = 1'b1;
  logic        tx_enb_n;
  logic [4:0]  tx_addr;
  logic [15:0] tx_data;
  logic        tx_sop, tx_eop, tx_mod, tx_err, tx_par;

  int n_chk = 0;
  int n_fail = 0;
  int mon_n = 0;
  int eop_cnt = 0;
  logic [15:0] mw_data [0:255];
  logic [3:0]  mw_flags [0:255];
  logic [4:0]  mw_addr [0:255];
  logic        prev_enb_n = 1'b1;
  logic [4:0]  prev_addr = 5'h1F;
  logic        prev_avail = 1'b1;
  bit          finished = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  pktx_link_tx dut_i (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_last(s_last), .s_err(s_err), .s_port(s_port),
    .par_odd(par_odd), .tx_avail(tx_avail), .tx_enb_n(tx_enb_n),
    .tx_addr(tx_addr), .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop),
    .tx_mod(tx_mod), .tx_err(tx_err), .tx_par(tx_par)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bus monitor, sampled away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(tx_par == ((^tx_data) ^ par_odd), "R8", "parity",
          int'(tx_par), int'((^tx_data) ^ par_odd));
      if (!tx_enb_n) begin
        chk(prev_avail, "R10", "word after avail low", int'(prev_avail), 1);
        chk(tx_addr != 5'h1F, "R9", "null address on word", tx_addr, 0);
        if (tx_sop)
          chk(prev_enb_n && prev_addr == tx_addr, "R2", "selection cycle",
              {prev_enb_n, 3'b0, prev_addr}, {1'b1, 3'b0, tx_addr});
        if (mon_n < 256) begin
          mw_data[mon_n]  = tx_data;
          mw_flags[mon_n] = {tx_sop, tx_eop, tx_mod, tx_err};
          mw_addr[mon_n]  = tx_addr;
        end
        mon_n++;
        if (tx_eop) eop_cnt++;
      end else begin
        chk({tx_sop, tx_eop, tx_mod, tx_err} == 4'b0 && tx_data == 16'h0, "R3",
            "quiet while disabled", {tx_sop, tx_eop, tx_mod, tx_err}, 0);
      end
      prev_enb_n = tx_enb_n;
      prev_addr  = tx_addr;
      prev_avail = tx_avail;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // err_last applies to the final byte; other bytes carry s_err=1 as noise (R6)
  task automatic send_pkt(input int port, input int len, input bit err_last,
                          input int base);
    for (int i = 0; i < len; i++) begin
      bit got;
      s_valid = 1'b1;
      s_data  = 8'(base + i);
      s_last  = (i == len - 1);
      s_err   = (i == len - 1) ? err_last : 1'b1;
      s_port  = 5'(port);
      got = 1'b0;
      while (!got) begin
        @(negedge clk);
        got = s_ready;
        tick();
      end
    end
    s_valid = 1'b0;
    s_last  = 1'b0;
    s_err   = 1'b0;
  endtask

  task automatic wait_eops(input int target, input string req);
    int n = 0;
    while (eop_cnt < target && n < 3000) begin
      tick();
      n++;
    end
    chk(eop_cnt >= target, req, "packet end seen", eop_cnt, target);
  endtask

  task automatic cmp_pkt(input int idx, input int port, input int len,
                         input bit err, input int base);
    int nw;
    nw = (len <= 2) ? 2 : (len + 1) / 2;
    for (int k = 0; k < nw; k++) begin
      logic [7:0]  hi, lo;
      logic [15:0] ed;
      logic [3:0]  ef;
      bit          last_w;
      last_w = (k == nw - 1);
      if (len <= 2) begin
        hi = (k == 0) ? 8'(base) : ((len == 2) ? 8'(base + 1) : 8'h00);
        lo = 8'h00;
        ef = (k == 0) ? 4'b1000 : {2'b01, 1'b1, err};
      end else begin
        hi = 8'(base + 2 * k);
        lo = (2 * k + 1 < len) ? 8'(base + 2 * k + 1) : 8'h00;
        ef = {k == 0, last_w, last_w && (len % 2 == 1), last_w && err};
      end
      ed = {hi, lo};
      chk(mw_data[idx + k] == ed, (len <= 2) ? "R7" : ((last_w && len % 2 == 1) ? "R5" : "R4"),
          "word data", mw_data[idx + k], ed);
      chk(mw_flags[idx + k] == ef, (len <= 2) ? "R7" : "R6", "sop/eop/mod/err",
          mw_flags[idx + k], ef);
      chk(mw_addr[idx + k] == 5'(port), "R2", "address held", mw_addr[idx + k], port);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(tx_enb_n == 1'b1 && tx_addr == 5'h1F, "R1", "idle enable/address",
        {tx_enb_n, 3'b0, tx_addr}, 8'h9F);
    chk({tx_sop, tx_eop, tx_mod, tx_err} == 4'b0 && tx_data == 16'h0, "R1",
        "idle flags/data", {tx_sop, tx_eop, tx_mod, tx_err}, 0);
    chk(s_ready == 1'b1, "R1", "ready after reset", int'(s_ready), 1);
    tick();
  endtask

  task automatic t_even();
    int s0 = mon_n, e0 = eop_cnt;
    send_pkt(3, 6, 1'b0, 8'h10);
    wait_eops(e0 + 1, "R3");
    chk(mon_n - s0 == 3, "R4", "even word count", mon_n - s0, 3);
    cmp_pkt(s0, 3, 6, 1'b0, 8'h10);
  endtask

  task automatic t_odd_err();
    int s0 = mon_n, e0 = eop_cnt;
    send_pkt(7, 7, 1'b1, 8'hA0);
    wait_eops(e0 + 1, "R5");
    chk(mon_n - s0 == 4, "R5", "odd word count", mon_n - s0, 4);
    cmp_pkt(s0, 7, 7, 1'b1, 8'hA0);
    s0 = mon_n;
    send_pkt(2, 5, 1'b0, 8'h40);
    wait_eops(e0 + 2, "R6");
    cmp_pkt(s0, 2, 5, 1'b0, 8'h40);
  endtask

  task automatic t_short();
    int s0 = mon_n, e0 = eop_cnt;
    send_pkt(4, 1, 1'b1, 8'h5A);
    wait_eops(e0 + 1, "R7");
    chk(mon_n - s0 == 2, "R7", "one-byte word count", mon_n - s0, 2);
    cmp_pkt(s0, 4, 1, 1'b1, 8'h5A);
    s0 = mon_n;
    send_pkt(9, 2, 1'b0, 8'hC3);
    wait_eops(e0 + 2, "R7");
    chk(mon_n - s0 == 2, "R7", "two-byte word count", mon_n - s0, 2);
    cmp_pkt(s0, 9, 2, 1'b0, 8'hC3);
  endtask

  task automatic t_parity_odd();
    int s0 = mon_n, e0 = eop_cnt;
    par_odd = 1'b1;
    send_pkt(1, 9, 1'b0, 8'h33);
    wait_eops(e0 + 1, "R8");
    cmp_pkt(s0, 1, 9, 1'b0, 8'h33);
    tick();
    par_odd = 1'b0;
  endtask

  task automatic t_stall();
    int s0 = mon_n, e0 = eop_cnt;
    tx_avail = 1'b0;
    fork
      send_pkt(6, 10, 1'b0, 8'h70);
      begin
        repeat (30) tick();
        chk(mon_n == s0, "R10", "no word while avail low", mon_n - s0, 0);
        // toggle the flag while the packet drains
        while (eop_cnt == e0) begin
          tx_avail = 1'b1;
          tick();
          tx_avail = 1'b0;
          repeat (2) tick();
        end
        tx_avail = 1'b1;
      end
    join
    wait_eops(e0 + 1, "R10");
    chk(mon_n - s0 == 5, "R10", "no loss or repeat", mon_n - s0, 5);
    cmp_pkt(s0, 6, 10, 1'b0, 8'h70);
  endtask

  task automatic t_back2back();
    int s0 = mon_n, e0 = eop_cnt;
    send_pkt(11, 4, 1'b0, 8'h01);
    send_pkt(20, 3, 1'b1, 8'h91);
    wait_eops(e0 + 2, "R11");
    chk(mon_n - s0 == 4, "R11", "two packet word count", mon_n - s0, 4);
    cmp_pkt(s0, 11, 4, 1'b0, 8'h01);
    cmp_pkt(s0 + 2, 20, 3, 1'b1, 8'h91);
  endtask

  task automatic t_idle();
    repeat (3) tick();
    @(negedge clk);
    chk(tx_enb_n == 1'b1 && tx_addr == 5'h1F, "R9", "back to null address",
        {tx_enb_n, 3'b0, tx_addr}, 8'h9F);
    tick();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_even();
    t_odd_err();
    t_short();
    t_parity_odd();
    t_stall();
    t_back2back();
    t_idle();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule